// File: doc/BRIEF.md
# Register-Based Transmit Descriptor Ring Sequencer

This block is the transmit sequencer of an Ethernet MAC whose descriptor ring is a small set of hardware registers rather than a list in memory. Each ring entry is a group of three registers: a completion status, a buffer pointer with ownership flags, and a frame length. Software loads the length and the buffer pointer and then hands the entry to hardware by setting its enable flag. The sequencer serves the entries strictly in ring order. For each enabled entry it offers the frame to a transmit engine, waits for that engine to report the end of the frame, writes the reported status back, returns ownership to software and pulses an interrupt.

The memory fetch and the wire-side transmission are outside the block. They are represented by a valid/ready offer (`frame_valid`, `frame_ready`) and a one-cycle completion strobe (`tx_done`) with its status word. Register reads are combinational by default. A parameter selects a registered read path instead.

Top module: `txring_seq`

## Requirements
- R1: After reset, and after any later reset, every status, pointer and length register reads 0, the index field reads 0, and `frame_valid` and `irq` are low.
- R2: Entry n occupies byte offsets n*0x10 to n*0x10+0xF. Status is at +0x0, the pointer register at +0x4 and the length at +0x8. The length keeps its low LEN_W bits (14 by default). Offset +0xC reads 0.
- R3: Bits 3:2 of every pointer register read the index of the entry the hardware serves next, the same value in every entry. Values written to those bits are ignored. Bits 31:4 read back the written buffer address.
- R4: When the entry at the current index has bit 0 (enable) of its pointer register set, `frame_valid` rises with `frame_addr` = {bits 31:4, 4'b0} and `frame_len` = the entry's length. Both stay stable until `frame_ready` is seen.
- R5: A `tx_done` strobe after the frame was accepted completes the entry. In the next cycle its enable bit (bit 0) reads 0, its done bit (bit 1) reads 1 and its status register holds `tx_status`. `irq` is high for exactly that one cycle.
- R6: Each completion advances the index by one modulo NUM_ENT, so entries are served 0,1,2,3,0,...
- R7: While the entry at the current index is not enabled, the sequencer waits there with `frame_valid` low, even if other entries are enabled.
- R8: The status register is read-only, and writes to +0x0 are ignored. It holds the 14-bit transmit status unchanged in bits 13:0: bit 0 aborted, 1 jabber, 2 no carrier, 3 carrier lost, 4 excessive deferral, 5 late-collision abort, 6 excessive collisions, 7 underrun, 8 deferred, 9 late collision, 13:10 collision count. Bits 31:14 read 0.
- R9: A write to the pointer register replaces bits 31:4 and both control bits together, so writing bit 1 = 0 acknowledges a completion. When such a write lands in the same cycle as that entry's completion, the hardware's control values win, and the address bits still take the written value.
- R10: Address and length are captured when the frame is offered. Rewriting the entry's registers during the offer does not change `frame_addr` or `frame_len`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | $clog2(NUM_ENT)+4 | Register byte offset (read and write) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| frame_valid | output | 1 | Frame offered to the transmit engine |
| frame_addr | output | 32 | Buffer address of the offered frame |
| frame_len | output | LEN_W | Length of the offered frame |
| frame_ready | input | 1 | Transmit engine accepts the offer |
| tx_done | input | 1 | Transmit engine finished the accepted frame |
| tx_status | input | 14 | Completion status that goes with `tx_done` |
| irq | output | 1 | One-cycle pulse per completed entry |

## Verification
The bench first enables an entry that is not the current one. A sequencer that searched ahead for any enabled entry would transmit it out of order. It then writes a pointer register in the very cycle its entry completes. A design that let software win would leave the entry owned by hardware and lose the done flag. It rewrites the buffer address while a frame is still offered, which exposes a design that drives the offer straight from the live registers. Finally, it runs the ring past entry 3 and reads the index field from several entries, so a wrong wrap or a per-entry index shows up as a wrong next entry or a mismatching field.

// File: rtl/txr_pkg.sv
package txr_pkg;

   // word select inside one entry (byte offset bits 3:2)
   localparam logic [1:0] WSEL_STAT = 2'd0;
   localparam logic [1:0] WSEL_PTR  = 2'd1;
   localparam logic [1:0] WSEL_LEN  = 2'd2;

   localparam int unsigned STAT_W = 14;
   localparam int unsigned BUF_W  = 28;   // pointer bits 31:4

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_OFFER = 2'd1,
      SQ_BUSY  = 2'd2
   } sq_state_e;

   // completion status, bit 0 first from the bottom
   typedef struct packed {
      logic [3:0] coll_cnt;
      logic       late_coll;
      logic       deferred;
      logic       underrun;
      logic       excess_coll;
      logic       late_abort;
      logic       excess_defer;
      logic       carrier_lost;
      logic       no_carrier;
      logic       jabber;
      logic       aborted;
   } txr_stat_t;

endpackage

// File: rtl/txr_entry.sv
module txr_entry
   import txr_pkg::*;
#(
   parameter int unsigned LEN_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_ptr_we,
   input  logic             sw_len_we,
   input  logic [31:0]      sw_wdata,
   input  logic             hw_cmpl,
   input  txr_stat_t        hw_stat,
   output logic [BUF_W-1:0] buf_q,
   output logic             en_q,
   output logic             done_q,
   output logic [LEN_W-1:0] len_q,
   output txr_stat_t        stat_q
);

   // buffer address: software only
   always_ff @(posedge clk) begin
      if (!rst_n)         buf_q <= '0;
      else if (sw_ptr_we) buf_q <= sw_wdata[31:4];
   end

   // control bits: completion has priority over a software write
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         done_q <= 1'b0;
      end else if (hw_cmpl) begin
         en_q   <= 1'b0;
         done_q <= 1'b1;
      end else if (sw_ptr_we) begin
         en_q   <= sw_wdata[0];
         done_q <= sw_wdata[1];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         len_q <= '0;
      else if (sw_len_we) len_q <= sw_wdata[LEN_W-1:0];
   end

   // status: hardware only
   always_ff @(posedge clk) begin
      if (!rst_n)       stat_q <= '0;
      else if (hw_cmpl) stat_q <= hw_stat;
   end

endmodule

// File: rtl/txr_seq_fsm.sv
module txr_seq_fsm
   import txr_pkg::*;
#(
   parameter int unsigned NUM_ENT = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_ENT-1:0]         en_vec,
   input  logic                       frame_ready,
   input  logic                       tx_done,
   output logic [$clog2(NUM_ENT)-1:0] idx,
   output logic                       launch,
   output logic                       offer,
   output logic [NUM_ENT-1:0]         cmpl_vec,
   output logic                       irq
);

   localparam int unsigned IDX_W = $clog2(NUM_ENT);

   sq_state_e st;
   logic      cmpl;

   always_comb begin
      launch = (st == SQ_IDLE) && en_vec[idx];
      cmpl   = (st == SQ_BUSY) && tx_done;
      offer  = (st == SQ_OFFER);
      for (int i = 0; i < NUM_ENT; i++) begin
         cmpl_vec[i] = cmpl && (idx == IDX_W'(i));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st  <= SQ_IDLE;
         idx <= '0;
         irq <= 1'b0;
      end else begin
         irq <= cmpl;
         unique case (st)
            SQ_IDLE:  if (launch) st <= SQ_OFFER;
            SQ_OFFER: if (frame_ready) st <= SQ_BUSY;
            SQ_BUSY: begin
               if (tx_done) begin
                  st  <= SQ_IDLE;
                  idx <= idx + 1'b1;   // power-of-two ring wraps naturally
               end
            end
            default:  st <= SQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/txr_rdmux.sv
module txr_rdmux
   import txr_pkg::*;
#(
   parameter int unsigned NUM_ENT = 4,
   parameter int unsigned LEN_W   = 14,
   parameter bit          RD_REG  = 1'b0
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [$clog2(NUM_ENT)+3:0]       rd_addr,
   input  logic [NUM_ENT-1:0][BUF_W-1:0]    buf_vec,
   input  logic [NUM_ENT-1:0]               en_vec,
   input  logic [NUM_ENT-1:0]               done_vec,
   input  logic [NUM_ENT-1:0][LEN_W-1:0]    len_vec,
   input  logic [NUM_ENT-1:0][STAT_W-1:0]   stat_vec,
   input  logic [$clog2(NUM_ENT)-1:0]       idx,
   output logic [31:0]                      rdata
);

   localparam int unsigned IDX_W = $clog2(NUM_ENT);

   logic [IDX_W-1:0] sel;
   logic [31:0]      mux;
   logic [1:0]       unused_lo;

   assign unused_lo = rd_addr[1:0];
   assign sel       = rd_addr[IDX_W+3:4];

   always_comb begin
      mux = '0;
      case (rd_addr[3:2])
         WSEL_STAT: mux = 32'(stat_vec[sel]);
         WSEL_PTR:  mux = {buf_vec[sel], 2'(idx), done_vec[sel], en_vec[sel]};
         WSEL_LEN:  mux = 32'(len_vec[sel]);
         default:   mux = '0;
      endcase
   end

   generate
      if (RD_REG) begin : g_rd_flop
         always_ff @(posedge clk) begin
            if (!rst_n) rdata <= '0;
            else        rdata <= mux;
         end
      end else begin : g_rd_comb
         logic unused_ck;
         assign unused_ck = clk ^ rst_n;
         assign rdata     = mux;
      end
   endgenerate

endmodule

// File: rtl/txring_seq.sv
module txring_seq
   import txr_pkg::*;
#(
   parameter int unsigned NUM_ENT = 4,
   parameter int unsigned LEN_W   = 14,
   parameter bit          RD_REG  = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       reg_we,
   input  logic [$clog2(NUM_ENT)+3:0] reg_addr,
   input  logic [31:0]                reg_wdata,
   output logic [31:0]                reg_rdata,
   output logic                       frame_valid,
   output logic [31:0]                frame_addr,
   output logic [LEN_W-1:0]           frame_len,
   input  logic                       frame_ready,
   input  logic                       tx_done,
   input  logic [STAT_W-1:0]          tx_status,
   output logic                       irq
);

   localparam int unsigned IDX_W = $clog2(NUM_ENT);

   generate
      if (!(NUM_ENT == 2 || NUM_ENT == 4)) begin : g_bad_ent
         $fatal(1, "NUM_ENT must be 2 or 4 (index field is two bits)");
      end
      if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
         $fatal(1, "LEN_W must lie in 1..16");
      end
   endgenerate

   logic [NUM_ENT-1:0][BUF_W-1:0]  buf_vec;
   logic [NUM_ENT-1:0]             en_vec;
   logic [NUM_ENT-1:0]             done_vec;
   logic [NUM_ENT-1:0][LEN_W-1:0]  len_vec;
   logic [NUM_ENT-1:0][STAT_W-1:0] stat_vec;
   logic [NUM_ENT-1:0]             cmpl_vec;
   logic [IDX_W-1:0]               idx;
   logic                           launch;
   logic [IDX_W-1:0]               wr_sel;
   logic [BUF_W-1:0]               cur_buf;
   logic [LEN_W-1:0]               cur_len;

   assign wr_sel = reg_addr[IDX_W+3:4];

   for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
      logic      ptr_we, len_we;
      txr_stat_t st_q;

      assign ptr_we      = reg_we && (wr_sel == IDX_W'(g)) && (reg_addr[3:2] == WSEL_PTR);
      assign len_we      = reg_we && (wr_sel == IDX_W'(g)) && (reg_addr[3:2] == WSEL_LEN);
      assign stat_vec[g] = st_q;

      txr_entry #(.LEN_W(LEN_W)) i_entry (
         .clk       (clk),
         .rst_n     (rst_n),
         .sw_ptr_we (ptr_we),
         .sw_len_we (len_we),
         .sw_wdata  (reg_wdata),
         .hw_cmpl   (cmpl_vec[g]),
         .hw_stat   (txr_stat_t'(tx_status)),
         .buf_q     (buf_vec[g]),
         .en_q      (en_vec[g]),
         .done_q    (done_vec[g]),
         .len_q     (len_vec[g]),
         .stat_q    (st_q)
      );
   end

   txr_seq_fsm #(.NUM_ENT(NUM_ENT)) i_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .en_vec      (en_vec),
      .frame_ready (frame_ready),
      .tx_done     (tx_done),
      .idx         (idx),
      .launch      (launch),
      .offer       (frame_valid),
      .cmpl_vec    (cmpl_vec),
      .irq         (irq)
   );

   // frame fields are captured once, when the offer starts
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_buf <= '0;
         cur_len <= '0;
      end else if (launch) begin
         cur_buf <= buf_vec[idx];
         cur_len <= len_vec[idx];
      end
   end

   assign frame_addr = {cur_buf, 4'b0000};
   assign frame_len  = cur_len;

   txr_rdmux #(.NUM_ENT(NUM_ENT), .LEN_W(LEN_W), .RD_REG(RD_REG)) i_rdmux (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_addr  (reg_addr),
      .buf_vec  (buf_vec),
      .en_vec   (en_vec),
      .done_vec (done_vec),
      .len_vec  (len_vec),
      .stat_vec (stat_vec),
      .idx      (idx),
      .rdata    (reg_rdata)
   );

endmodule

// File: rtl/txr_chk.sv
module txr_chk #(
   parameter int unsigned NUM_ENT = 4,
   parameter int unsigned LEN_W   = 14
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       frame_valid,
   input logic                       frame_ready,
   input logic [31:0]                frame_addr,
   input logic [LEN_W-1:0]           frame_len,
   input logic                       tx_done,
   input logic                       irq,
   input logic [$clog2(NUM_ENT)-1:0] idx,
   input logic [NUM_ENT-1:0]         en_vec,
   input logic [NUM_ENT-1:0]         cmpl_vec
);

   localparam int unsigned IDX_W = $clog2(NUM_ENT);

   p_offer_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid && !frame_ready |=> frame_valid && $stable(frame_addr) && $stable(frame_len));

   p_offer_owned_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_valid) |-> $past(en_vec[idx]));

   p_irq_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(tx_done));

   p_irq_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   p_one_cmpl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cmpl_vec));

   p_idx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(|cmpl_vec) |=> $stable(idx));

   p_idx_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|cmpl_vec) |=> idx == IDX_W'($past(idx) + 1'b1));

   p_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !en_vec[idx] && !frame_valid |=> !frame_valid);

endmodule

bind txring_seq txr_chk #(.NUM_ENT(NUM_ENT), .LEN_W(LEN_W)) i_txr_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .frame_valid (frame_valid),
   .frame_ready (frame_ready),
   .frame_addr  (frame_addr),
   .frame_len   (frame_len),
   .tx_done     (tx_done),
   .irq         (irq),
   .idx         (idx),
   .en_vec      (en_vec),
   .cmpl_vec    (cmpl_vec)
);

// File: tb/test_txring_seq.sv
`timescale 1ns/1ps
module test_txring_seq;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        reg_we;
   logic [5:0]  reg_addr;
   logic [31:0] reg_wdata;
   logic [31:0] reg_rdata;
   logic        frame_valid;
   logic [31:0] frame_addr;
   logic [13:0] frame_len;
   logic        frame_ready;
   logic        tx_done;
   logic [13:0] tx_status;
   logic        irq;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;   // 50 MHz

   txring_seq i_txring_seq (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_valid(frame_valid),
      .frame_addr(frame_addr), .frame_len(frame_len), .frame_ready(frame_ready),
      .tx_done(tx_done), .tx_status(tx_status), .irq(irq)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(int a, logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 6'(a); reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(int a, output logic [31:0] v);
      @(negedge clk);
      reg_addr = 6'(a);
      #1 v = reg_rdata;
   endtask

   task automatic wait_offer(string tag);
      int n = 0;
      while (!frame_valid && n < 6) begin
         @(negedge clk);
         n++;
      end
      chk({tag, " offer seen"}, 32'(frame_valid), 32'd1);
   endtask

   task automatic accept(logic [31:0] ea, int el, string tag);
      chk({tag, " frame_addr"}, frame_addr, ea);
      chk({tag, " frame_len"}, 32'(frame_len), 32'(el));
      @(negedge clk);
      chk({tag, " offer held"}, {frame_addr[31:1], frame_valid}, {ea[31:1], 1'b1});
      frame_ready = 1'b1;
      @(negedge clk);
      frame_ready = 1'b0;
      chk({tag, " offer gone"}, 32'(frame_valid), 32'd0);
   endtask

   task automatic complete(int ent, logic [31:0] ebuf, int nxt, logic [13:0] st, string tag);
      logic [31:0] v;
      tx_status = st; tx_done = 1'b1;
      @(negedge clk);
      tx_done = 1'b0;
      #1 chk({tag, " irq pulse"}, 32'(irq), 32'd1);
      rd(ent * 16 + 4, v);
      chk({tag, " irq single"}, 32'(irq), 32'd0);
      chk({tag, " ptr after completion"}, v, ebuf | (32'(nxt) << 2) | 32'h2);
      rd(ent * 16, v);
      chk({tag, " status writeback"}, v, 32'(st));
   endtask

   task automatic t_reset;
      logic [31:0] v;
      chk("R1 frame_valid at reset", 32'(frame_valid), 0);
      chk("R1 irq at reset", 32'(irq), 0);
      for (int e = 0; e < 4; e++) begin
         for (int w = 0; w < 3; w++) begin
            rd(e * 16 + w * 4, v);
            chk("R1 register after reset", v, 0);
         end
      end
   endtask

   task automatic t_layout;
      logic [31:0] v;
      wr(16'h14, 32'hABCDEF5D);
      rd(16'h14, v); chk("R3 index bits ignore writes, R2 ptr readback", v, 32'hABCDEF51);
      wr(16'h18, 32'hFFFFC5EE);
      rd(16'h18, v); chk("R2 length keeps LEN_W bits", v, 32'h000005EE);
      rd(16'h1C, v); chk("R2 offset 0xC reads zero", v, 0);
      wr(16'h10, 32'hFFFFFFFF);
      rd(16'h10, v); chk("R8 status write ignored", v, 0);
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk("R7 waits on disabled current entry", 32'(frame_valid), 0);
      end
      wr(16'h14, 32'h0);
      rd(16'h14, v); chk("R9 ptr write clears control", v, 0);
   endtask

   task automatic t_first;
      logic [31:0] v;
      wr(16'h08, 32'd64);
      wr(16'h04, 32'h12345671);
      wait_offer("R4 entry0");
      wr(16'h04, 32'h99999991);
      chk("R10 offer address captured", frame_addr, 32'h12345670);
      accept(32'h12345670, 64, "R4 entry0");
      complete(0, 32'h99999990, 1, 14'h2A5, "R5 R8 entry0");
      rd(16'h14, v); chk("R3 index seen in other entry", v, 32'h00000004);
      wr(16'h04, 32'h99999990);
      rd(16'h04, v); chk("R9 software ack clears done", v, 32'h99999994);
   endtask

   task automatic t_order;
      wr(16'h38, 32'd100);
      wr(16'h34, 32'h30000001);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk("R7 no skip to later entry", 32'(frame_valid), 0);
      end
      wr(16'h28, 32'd200);
      wr(16'h24, 32'h20000001);
      wr(16'h18, 32'd300);
      wr(16'h14, 32'h10000001);
      wait_offer("R6 entry1");
      accept(32'h10000000, 300, "R6 entry1");
      complete(1, 32'h10000000, 2, 14'h3C00, "R6 R8 entry1");
      wait_offer("R6 entry2");
      accept(32'h20000000, 200, "R6 entry2");
      complete(2, 32'h20000000, 3, 14'h0001, "R6 entry2");
      wait_offer("R6 entry3");
      accept(32'h30000000, 100, "R6 entry3");
      complete(3, 32'h30000000, 0, 14'h0080, "R6 entry3 wrap");
      wr(16'h08, 32'd60);
      wr(16'h04, 32'h40000001);
      wait_offer("R6 entry0 again");
      accept(32'h40000000, 60, "R6 entry0 again");
      complete(0, 32'h40000000, 1, 14'h0400, "R6 entry0 again");
   endtask

   task automatic t_collide;
      logic [31:0] v;
      wr(16'h14, 32'h50000001);
      wait_offer("R9 collide");
      accept(32'h50000000, 300, "R9 collide");
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 6'h14; reg_wdata = 32'h60000001;
      tx_status = 14'h0002; tx_done = 1'b1;
      @(negedge clk);
      reg_we = 1'b0; tx_done = 1'b0;
      #1 chk("R9 collide irq", 32'(irq), 1);
      rd(16'h14, v); chk("R9 hardware control wins, address from write", v, 32'h6000000A);
      rd(16'h10, v); chk("R9 collide status", v, 32'h2);
   endtask

   task automatic t_reset_mid;
      logic [31:0] v;
      wr(16'h24, 32'h70000001);
      wait_offer("R1 before reset");
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      #1 chk("R1 offer dropped by reset", 32'(frame_valid), 0);
      rd(16'h24, v); chk("R1 ptr cleared", v, 0);
      rd(16'h20, v); chk("R1 status cleared", v, 0);
      rd(16'h28, v); chk("R1 length cleared", v, 0);
      rd(16'h04, v); chk("R1 index back to zero", v, 0);
   endtask

   initial begin
      rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
      frame_ready = 1'b0; tx_done = 1'b0; tx_status = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_layout();
      t_first();
      t_order();
      t_collide();
      t_reset_mid();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 20000);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule